// File: doc/BRIEF.md
# Saturating-Stop Signed Step Counter

This block holds a signed two's-complement count and moves it by a signed step on command. A synchronous reset loads a start value. Each cycle, a single-cycle up strobe adds the step to the count and a down strobe subtracts it.

The block checks every step for signed overflow before committing it. If the result would fall outside the representable range, the count keeps its old value and a sticky overflow flag rises. While that flag is set the count is frozen, and only reset brings the block back into service.

A typical use is to apply reset with a start value and a step, then pulse one direction repeatedly until the count stops changing. The last committed value is then the furthest point reachable without wrapping.

Top module: `sgn_step_counter`

## Requirements
- R1: The count, start value and step are WIDTH-bit signed two's-complement numbers (default 8, range -128 to +127), and every intermediate keeps the correct sign.
- R2: While rst is high at a rising clock edge, the count loads start_val and ovf clears to 0, in that same edge.
- R3: With step_up high, step_dn low and ovf low, an in-range result count+step_val is committed at the next edge.
- R4: With step_dn high, step_up low and ovf low, the result count-step_val is formed as count + (~step_val + 1) and, if it is in range, committed at the next edge.
- R5: A step whose true result lies outside the signed range leaves the count unchanged and sets ovf at the next edge. For addition, this is the case when both addends share a sign and the sum's sign differs.
- R6: Once ovf is 1 it stays 1 until reset, and the count does not change under any strobe while ovf is 1.
- R7: When step_up and step_dn are both high in the same cycle, neither count nor ovf changes.
- R8: Subtracting the most negative step value overflows exactly when the count is non-negative. From a negative count it yields the correct positive result.
- R9: start_val has no effect on the count while rst is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads start_val |
| start_val | input | WIDTH | Signed value loaded at reset |
| step_val | input | WIDTH | Signed increment used by each step |
| step_up | input | 1 | One-cycle strobe: add step_val |
| step_dn | input | 1 | One-cycle strobe: subtract step_val |
| count | output | WIDTH | Signed counter value |
| ovf | output | 1 | Sticky signed-overflow flag |

## Verification
The main function is run from four start/step pairs. Each pairing of start sign, step sign and direction leads to a different exit. The runs end by overflowing past the top of the range, past the bottom of the range, and by landing exactly on -128 before overflowing on the next step. Further patterns target three cases that the four runs cannot tell apart from a correct design:
- subtracting -128 from zero and from -1, which separates a proper subtraction overflow rule from a naive rule applied to the negated addend;
- simultaneous strobes;
- strobes and start-value changes while frozen or out of reset.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Overflow rule for a + b = r, judged on sign bits only
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Overflow rule for a - b = r, judged on sign bits only
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/cnt_negate.sv
module cnt_negate #(
  parameter int WIDTH = 8
) (
  input  logic signed [WIDTH-1:0] val,
  output logic signed [WIDTH-1:0] neg
);
  assign neg = ~val + 1'b1;

  // R4: a value plus its negation is zero modulo 2^WIDTH
  always_comb begin
    if (!$isunknown(val)) begin
      a_r4_negate_sum_zero: assert (WIDTH'(val + neg) == '0);
    end
  end
endmodule

// File: rtl/cnt_adder.sv
module cnt_adder #(
  parameter int WIDTH = 8
) (
  input  logic signed [WIDTH-1:0] acc,
  input  logic signed [WIDTH-1:0] step,
  input  logic signed [WIDTH-1:0] neg_step,
  input  logic                    sub,
  output logic signed [WIDTH-1:0] sum,
  output logic                    hit_ovf
);
  import cnt_pkg::*;
  localparam int MSB = WIDTH - 1;
  localparam logic signed [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic signed [WIDTH-1:0] rhs;

  assign rhs = sub ? neg_step : step;
  assign sum = acc + rhs;
  assign hit_ovf = sub ? sub_ovf(acc[MSB], step[MSB], sum[MSB])
                       : add_ovf(acc[MSB], rhs[MSB], sum[MSB]);

  // R8: subtracting the most negative value overflows iff acc is non-negative
  always_comb begin
    if (!$isunknown({acc, step, sub}) && sub && step == MOST_NEG) begin
      a_r8_min_subtrahend: assert (hit_ovf == !acc[MSB]);
    end
  end
endmodule

// File: rtl/sgn_step_counter.sv
module sgn_step_counter #(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [WIDTH-1:0] start_val,
  input  logic signed [WIDTH-1:0] step_val,
  input  logic                    step_up,
  input  logic                    step_dn,
  output logic signed [WIDTH-1:0] count,
  output logic                    ovf
);
  logic signed [WIDTH-1:0] neg_step;
  logic signed [WIDTH-1:0] next_sum;
  logic                    hit_ovf;
  logic                    go_up, go_dn, attempt, commit, blocked;

  // Exactly one direction requested, and the counter is not frozen
  assign go_up   = step_up & ~step_dn;
  assign go_dn   = step_dn & ~step_up;
  assign attempt = (go_up | go_dn) & ~ovf;
  assign commit  = attempt & ~hit_ovf;
  assign blocked = attempt &  hit_ovf;

  cnt_negate #(.WIDTH(WIDTH)) u_neg (
    .val (step_val),
    .neg (neg_step)
  );

  cnt_adder #(.WIDTH(WIDTH)) u_add (
    .acc      (count),
    .step     (step_val),
    .neg_step (neg_step),
    .sub      (go_dn),
    .sum      (next_sum),
    .hit_ovf  (hit_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= start_val;
      ovf   <= 1'b0;
    end else begin
      if (commit)  count <= next_sum;
      if (blocked) ovf   <= 1'b1;
    end
  end

  // R2: reset loads the start value and clears the flag
  a_r2_reset_load: assert property (@(posedge clk)
    rst |=> (count == $past(start_val)) && !ovf);

  // R5: a blocked step holds the count and raises the flag
  a_r5_block_holds: assert property (@(posedge clk) disable iff (rst)
    blocked |=> $stable(count) && ovf);

  // R6: the flag is sticky outside reset
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R6: a frozen counter never moves
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(count));

  // R7: conflicting strobes change nothing
  a_r7_conflict: assert property (@(posedge clk) disable iff (rst)
    (step_up && step_dn) |=> $stable(count) && $stable(ovf));
endmodule

// File: tb/sim_sgn_step_counter.sv
`timescale 1ns/1ps
module sim_sgn_step_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [7:0] start_val = '0;
  logic signed [7:0] step_val  = '0;
  logic step_up = 1'b0;
  logic step_dn = 1'b0;
  logic signed [7:0] count;
  logic ovf;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic signed [7:0] q;
    logic              f;
    string             tag;
  } exp_t;
  exp_t sb[$];
  exp_t e_mon;

  int mq;
  int mf;

  always #10 clk = ~clk;

  sgn_step_counter #(.WIDTH(8)) u0 (
    .clk(clk), .rst(rst), .start_val(start_val), .step_val(step_val),
    .step_up(step_up), .step_dn(step_dn), .count(count), .ovf(ovf)
  );

  function automatic exp_t mk(int q, int f, string tag);
    exp_t e;
    e.q = 8'(q);
    e.f = f[0];
    e.tag = tag;
    return e;
  endfunction

  // Monitor: compare one expected item after each edge it belongs to
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      e_mon = sb.pop_front();
      n_tests++;
      if (count !== e_mon.q || ovf !== e_mon.f) begin
        n_fail++;
        $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                 e_mon.tag, count, ovf, e_mon.q, e_mon.f);
      end
    end
  end

  task automatic do_reset(int a, int b, string tag);
    @(negedge clk);
    rst = 1'b1; start_val = 8'(a); step_val = 8'(b);
    mq = a; mf = 0;
    sb.push_back(mk(mq, mf, tag));
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: apply strobes and push the reference result (wide integer model)
  task automatic do_step(bit u, bit d, string tag);
    int nv;
    @(negedge clk);
    step_up = u; step_dn = d;
    if ((u ^ d) && mf == 0) begin
      nv = u ? mq + int'(step_val) : mq - int'(step_val);
      if (nv > 127 || nv < -128) mf = 1;
      else mq = nv;
    end
    sb.push_back(mk(mq, mf, tag));
    @(negedge clk);
    step_up = 1'b0; step_dn = 1'b0;
  endtask

  // Hand-computed end point, independent of the model
  task automatic check_end(int q, int f, string tag);
    @(negedge clk);
    n_tests++;
    if (count !== 8'(q) || ovf !== f[0]) begin
      n_fail++;
      $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
               tag, count, ovf, q, f);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R2 + R4: -47 stepping down by -43 climbs to 125 then stops
    do_reset(-47, -43, "R2 reset load");
    repeat (6) do_step(0, 1, "R4 down step");
    check_end(125, 1, "R5 top overflow stop");
    // R3 + R1: 29 stepping up by -17 crosses zero and stops at -124
    do_reset(29, -17, "R2 reset load");
    repeat (11) do_step(1, 0, "R3 up step");
    check_end(-124, 1, "R1 bottom overflow stop");
    // R5: -17 down by 37 lands exactly on -128
    do_reset(-17, 37, "R2 reset load");
    repeat (5) do_step(0, 1, "R5 reach min");
    check_end(-128, 1, "R5 exact min then stop");
    // 53 up by 13 stops at 118
    do_reset(53, 13, "R2 reset load");
    repeat (7) do_step(1, 0, "R3 up step");
    check_end(118, 1, "R5 top overflow stop");
    // R6: frozen under a step that would fit
    do_step(0, 1, "R6 frozen down");
    do_step(1, 0, "R6 frozen up");
    do_reset(53, 13, "R6 reset clears flag");
    // R7: both strobes together
    do_reset(10, 5, "R2 reset load");
    do_step(1, 1, "R7 conflict");
    do_step(1, 0, "R7 normal after conflict");
    check_end(15, 0, "R7 end value");
    // R8: subtract -128
    do_reset(0, -128, "R2 reset load");
    do_step(0, 1, "R8 zero minus min");
    check_end(0, 1, "R8 overflow from zero");
    do_reset(-1, -128, "R2 reset load");
    do_step(0, 1, "R8 neg minus min");
    check_end(127, 0, "R8 reaches 127");
    do_step(0, 1, "R8 second sub");
    // R5: add overflow at the bottom
    do_reset(-128, -1, "R2 reset load");
    do_step(1, 0, "R5 min plus -1");
    // R9: start value ignored outside reset
    do_reset(5, 3, "R2 reset load");
    @(negedge clk);
    start_val = 8'sd100;
    do_step(0, 0, "R9 start ignored");
    do_step(1, 0, "R9 step after change");
    check_end(8, 0, "R9 end value");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule